// File: doc/BRIEF.md
# Serial Flash Programming Slave

This block is the device side of an in-system programming link for an on-chip code memory. An external programmer drives a slow serial clock and a data line. The block samples both as asynchronous inputs on the system clock and decodes fixed-length command frames. It answers on a return data line. The commands enable programming, wipe the array, read or write single bytes, stream a whole 256-byte page, read identification bytes and raise a write-protection level.

Programming is possible only while the mode input is held high. A frame is acted on only after an enable frame has been accepted in that mode session. Byte writes and the erase are self-timed operations. Each one is modelled by a cycle counter, and the busy output is high for the whole count. While a byte write is running, the programmer can poll the location just written. The polled value has bit 7 inverted until the write cycle ends. Any code read made during an erase returns zero.

Top module: `isp_slave`

## Requirements
- R1: While `progMode` is low the bit and byte counters are held at zero and the enable flag is cleared. Until an enable frame (byte 0 = ACh, byte 1 = 53h) has been received with `progMode` high, writes, erase and lock frames are ignored and reads return 00h.
- R2: A frame is 4 bytes on `mosi`, MSB first. Each bit is taken on a rising edge of `sck`, after a two-flop synchronizer on the system clock. `miso` changes only in the system clock after a detected falling `sck` edge, MSB first. The reply byte of a single-byte command is byte 3, and `miso` is 0 after reset.
- R3: Byte write is opcode 40h. The address is {byte 1, byte 2}, taken modulo the array size, and the data is byte 3. `busy` goes high three system clocks after the `sck` rise that ends byte 3 and stays high for exactly WRITE_CYCLES clocks.
- R4: Byte read is opcode 20h, with the address in bytes 1 and 2. The stored byte is returned during byte 3.
- R5: While a write cycle runs, a read of the last written address returns that byte with bit 7 inverted and bits 6:0 unchanged. Reads of other addresses return the array contents.
- R6: Chip erase is opcode A8h. It sets every location to FFh, resets the lock level to 0 and holds `busy` for ERASE_CYCLES clocks. Every code read made during that time returns 00h.
- R7: Page write is opcode 50h. The low nibble of byte 1 gives address bits 11:8, and the next 256 bytes are written to offsets 00h to FFh in order. The write cycle then starts after the last byte, with polling on the last address.
- R8: Page read is opcode 30h, with the same address byte. It returns 256 bytes from offsets 00h to FFh in order. The frame then ends, and the next byte is decoded as an opcode.
- R9: Signature read is opcode 28h. Address 000h returns 1Eh, 100h returns 51h, 200h returns 06h and any other address returns 00h. All of them return 00h at lock level 3.
- R10: Lock write is opcode A4h, with the requested level in bits 1:0 of byte 3. It takes effect only when the request is exactly one above the current level. Level 00 and skipped levels are ignored, and only the erase lowers the level.
- R11: At lock level 1 or higher, byte and page writes are ignored. At lock level 2 or higher, byte and page reads return 00h.
- R12: Write, erase and lock frames that arrive while `busy` is high are ignored. A frame with any other opcode is 4 bytes long, changes nothing, and the byte that follows it is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progMode | input | 1 | Programming mode request, asynchronous, active high |
| sck | input | 1 | Serial clock from the programmer, at most 1/16 of `clk` |
| mosi | input | 1 | Serial command and data in |
| miso | output | 1 | Serial reply out |
| busy | output | 1 | High while a timed write or erase is in progress |

## Verification
The bench builds the block with ADDR_W = 10, so the 1 KiB array makes a page or byte address above 3FFh wrap. It sets WRITE_CYCLES = 2000 and ERASE_CYCLES = 1500, which let whole 4-byte frames fit inside a running write or erase. That puts the polled-MSB reads, the zero reads during erase and the frames rejected while busy within reach. The lengths are still short enough for two full page transfers and the whole lock-level ladder to fit in one run.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam logic [7:0] OP_ENABLE = 8'hAC;
  localparam logic [7:0] EN_KEY    = 8'h53;
  localparam logic [7:0] OP_ERASE  = 8'hA8;
  localparam logic [7:0] OP_LOCK   = 8'hA4;
  localparam logic [7:0] OP_RD     = 8'h20;
  localparam logic [7:0] OP_WR     = 8'h40;
  localparam logic [7:0] OP_SIG    = 8'h28;
  localparam logic [7:0] OP_PRD    = 8'h30;
  localparam logic [7:0] OP_PWR    = 8'h50;

  typedef enum logic [1:0] {
    TX_ZERO = 2'd0,
    TX_MEM  = 2'd1,
    TX_POLL = 2'd2,
    TX_SIG  = 2'd3
  } txSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        shiftIn;
    logic        loadOut;
    logic        shiftOut;
    logic        memWr;
    logic        eraseAll;
    txSel_e      txSel;
    logic [15:0] addr;
  } dpCtl_t;

endpackage

// File: rtl/isp_pin_sync.sv
module isp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic mosiIn,
  input  logic modeIn,
  output logic sckRise,
  output logic sckFall,
  output logic mosiS,
  output logic modeS
);

  logic [2:0] pipe [STAGES];
  logic       sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      sckPrev <= 1'b0;
    end else begin
      pipe[0] <= {modeIn, mosiIn, sckIn};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sckPrev <= pipe[STAGES-1][0];
    end
  end

  assign sckRise = pipe[STAGES-1][0] & ~sckPrev;
  assign sckFall = ~pipe[STAGES-1][0] & sckPrev;
  assign mosiS   = pipe[STAGES-1][1];
  assign modeS   = pipe[STAGES-1][2];

  // R2: one detected rise per sck transition
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    sckRise |=> !sckRise);

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl import isp_pkg::*; #(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 2000,
  parameter int ERASE_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       modeS,
  input  logic [7:0] rxByte,
  output dpCtl_t     ctl,
  output logic       busy
);

  localparam int LONGEST = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int TW = $clog2(LONGEST + 1);
  localparam logic [8:0] PAGE_LAST  = 9'd257;
  localparam logic [8:0] FRAME_LAST = 9'd3;

  logic [2:0]        bitCnt;
  logic [8:0]        byteIdx;
  logic [7:0]        opcode, arg1, arg2;
  logic              progEn;
  logic [1:0]        lockLvl;
  logic [TW-1:0]     tmr;
  logic              erasing;
  logic [ADDR_W-1:0] lastAddr;

  logic        byteDone, isPage, frameEnd, canMod, rdWanted;
  logic        doEnable, doWrite, doErase, doLock, startWr;
  logic [7:0]  pageOff;
  logic [15:0] accAddr;
  logic [1:0]  nextLvl;

  assign busy = (tmr != '0);

  always_comb begin
    byteDone = modeS && sckRise && (bitCnt == 3'd7);
    isPage   = (opcode == OP_PRD) || (opcode == OP_PWR);
    frameEnd = byteDone && (byteIdx == (isPage ? PAGE_LAST : FRAME_LAST));
    pageOff  = 8'(byteIdx - 9'd2);
    accAddr  = isPage ? {4'h0, arg1[3:0], pageOff} : {arg1, arg2};
    canMod   = progEn && !busy;
    nextLvl  = lockLvl + 2'd1;

    doEnable = byteDone && (byteIdx == 9'd3) && (opcode == OP_ENABLE) && (arg1 == EN_KEY);
    doErase  = byteDone && canMod && (byteIdx == 9'd3) && (opcode == OP_ERASE);
    doLock   = byteDone && canMod && (byteIdx == 9'd3) && (opcode == OP_LOCK)
               && (lockLvl != 2'd3) && (rxByte[1:0] == nextLvl);
    doWrite  = byteDone && canMod && (lockLvl == 2'd0)
               && (((opcode == OP_WR) && (byteIdx == 9'd3))
                   || ((opcode == OP_PWR) && (byteIdx >= 9'd2)));
    startWr  = doWrite && ((opcode == OP_WR) || (byteIdx == PAGE_LAST));

    rdWanted = ((opcode == OP_RD) && (byteIdx == 9'd3))
               || ((opcode == OP_PRD) && (byteIdx >= 9'd2));

    ctl          = '0;
    ctl.shiftIn  = modeS && sckRise;
    ctl.loadOut  = modeS && sckFall && (bitCnt == 3'd0);
    ctl.shiftOut = modeS && sckFall && (bitCnt != 3'd0);
    ctl.memWr    = doWrite;
    ctl.eraseAll = doErase;
    ctl.addr     = accAddr;

    if (!progEn) begin
      ctl.txSel = TX_ZERO;
    end else if ((opcode == OP_SIG) && (byteIdx == 9'd3)) begin
      ctl.txSel = (lockLvl == 2'd3) ? TX_ZERO : TX_SIG;
    end else if (rdWanted) begin
      if ((busy && erasing) || (lockLvl >= 2'd2))
        ctl.txSel = TX_ZERO;
      else if (busy && (accAddr[ADDR_W-1:0] == lastAddr))
        ctl.txSel = TX_POLL;
      else
        ctl.txSel = TX_MEM;
    end else begin
      ctl.txSel = TX_ZERO;
    end
  end

  // framing and command state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteIdx <= '0;
      opcode  <= '0;
      arg1    <= '0;
      arg2    <= '0;
      progEn  <= 1'b0;
    end else if (!modeS) begin
      bitCnt  <= '0;
      byteIdx <= '0;
      progEn  <= 1'b0;
    end else begin
      if (sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (byteIdx == 9'd0) opcode <= rxByte;
          if (byteIdx == 9'd1) arg1 <= rxByte;
          if ((byteIdx == 9'd2) && !isPage) arg2 <= rxByte;
          byteIdx <= frameEnd ? 9'd0 : byteIdx + 9'd1;
        end
      end
      if (doEnable) progEn <= 1'b1;
    end
  end

  // protection level and timed operations
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockLvl  <= '0;
      tmr      <= '0;
      erasing  <= 1'b0;
      lastAddr <= '0;
    end else begin
      if (doErase)     lockLvl <= 2'd0;
      else if (doLock) lockLvl <= rxByte[1:0];

      if (doErase) begin
        tmr     <= TW'(ERASE_CYCLES);
        erasing <= 1'b1;
      end else if (startWr) begin
        tmr      <= TW'(WRITE_CYCLES);
        erasing  <= 1'b0;
        lastAddr <= accAddr[ADDR_W-1:0];
      end else if (tmr != '0) begin
        tmr <= tmr - TW'(1);
      end
    end
  end

  // R10: level only climbs one step at a time, erase alone lowers it
  p_lock_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lockLvl != $past(lockLvl)) |-> ($past(ctl.eraseAll) || (lockLvl == $past(lockLvl) + 2'd1)));

  // R11: no array write once protected or before enable
  p_wr_unlocked_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWr |-> ((lockLvl == 2'd0) && progEn));

  // R3: a timed cycle starts only at a completed byte
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(byteDone));

  // R12: nothing is written while a timed cycle runs
  p_no_wr_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.memWr);

endmodule

// File: rtl/isp_datapath.sv
module isp_datapath import isp_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mosiS,
  input  dpCtl_t     ctl,
  output logic [7:0] rxByte,
  output logic       miso
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [6:0] inShift;
  logic [7:0] outShift;
  logic [7:0] rdByte, sigByte, txByte;

  assign rxByte = {inShift, mosiS};
  assign rdByte = mem[ctl.addr[ADDR_W-1:0]];
  assign miso   = outShift[7];

  always_ff @(posedge clk) begin
    if (ctl.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (ctl.memWr) begin
      mem[ctl.addr[ADDR_W-1:0]] <= rxByte;
    end
  end

  always_comb begin
    case (ctl.addr)
      16'h0000: sigByte = 8'h1E;
      16'h0100: sigByte = 8'h51;
      16'h0200: sigByte = 8'h06;
      default:  sigByte = 8'h00;
    endcase
    case (ctl.txSel)
      TX_MEM:  txByte = rdByte;
      TX_POLL: txByte = {~rdByte[7], rdByte[6:0]};
      TX_SIG:  txByte = sigByte;
      default: txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
    end else begin
      if (ctl.shiftIn)       inShift  <= rxByte[6:0];
      if (ctl.loadOut)       outShift <= txByte;
      else if (ctl.shiftOut) outShift <= {outShift[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/isp_slave.sv
module isp_slave import isp_pkg::*; #(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 2000,
  parameter int ERASE_CYCLES = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic progMode,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);

  logic       sckRise, sckFall, mosiS, modeS;
  logic [7:0] rxByte;
  dpCtl_t     ctl;

  isp_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sckIn(sck), .mosiIn(mosi), .modeIn(progMode),
    .sckRise(sckRise), .sckFall(sckFall), .mosiS(mosiS), .modeS(modeS)
  );

  isp_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall), .modeS(modeS),
    .rxByte(rxByte), .ctl(ctl), .busy(busy)
  );

  isp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .ctl(ctl), .rxByte(rxByte), .miso(miso)
  );

  // R2: reply line moves only after a detected falling sck edge
  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (miso != $past(miso)) |-> $past(sckFall));

endmodule

// File: tb/isp_slave_test.sv
module isp_slave_test;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int WC    = 2000;
  localparam int EC    = 1500;

  localparam logic [7:0] C_EN  = 8'hAC, C_KEY = 8'h53, C_ER  = 8'hA8, C_LK = 8'hA4;
  localparam logic [7:0] C_RD  = 8'h20, C_WR  = 8'h40, C_SG  = 8'h28;
  localparam logic [7:0] C_PRD = 8'h30, C_PWR = 8'h50;

  logic clk = 1'b0, rstN = 1'b0, progMode = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy;

  always #5 clk = ~clk;

  isp_slave #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rstN(rstN), .progMode(progMode), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  int nCmp = 0, nBad = 0;
  bit chkOn = 0, done = 0;

  // behavioural reference
  logic [7:0] mMem [DEPTH];
  bit mEn = 0, mErasing = 0;
  int mLock = 0, mTmr = 0, mPend = 0, pendLen = 0, mLastAddr = 0;

  always @(posedge clk) begin
    if (mPend > 0) begin
      mPend--;
      if (mPend == 0) mTmr = pendLen;
    end else if (mTmr > 0) begin
      mTmr--;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (chkOn) check("R3 R6 busy", {7'b0, busy}, {7'b0, (mTmr > 0)});

  function automatic logic [7:0] sigVal(logic [15:0] a);
    case (a)
      16'h0000: return 8'h1E;
      16'h0100: return 8'h51;
      16'h0200: return 8'h06;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] mRead(int a);
    bit act = (mTmr > 0) || (mPend > 0);
    if (!mEn) return 8'h00;
    if (act && mErasing) return 8'h00;
    if (mLock >= 2) return 8'h00;
    if (act && a == mLastAddr) return {~mMem[a][7], mMem[a][6:0]};
    return mMem[a];
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit startOp, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      waitClk(8);
      rx[i] = miso;
      sck = 1'b1;
      if (i == 0 && startOp) mPend = 3;
      waitClk(8);
      sck = 1'b0;
    end
  endtask

  task automatic frame(string tag, logic [7:0] op, logic [7:0] a1, logic [7:0] a2, logic [7:0] d);
    logic [7:0] r, exp;
    int a;
    bit start, canMod;
    a = int'({a1, a2}) % DEPTH;
    xfer(op, 1'b0, r);
    xfer(a1, 1'b0, r);
    xfer(a2, 1'b0, r);
    canMod = mEn && mTmr == 0 && mPend == 0;
    exp = 8'h00;
    start = 1'b0;
    if (op == C_RD) exp = mRead(a);
    if (op == C_SG) exp = (mEn && mLock != 3) ? sigVal({a1, a2}) : 8'h00;
    if (op == C_WR && canMod && mLock == 0) begin
      start = 1'b1; pendLen = WC; mErasing = 1'b0; mLastAddr = a;
    end
    if (op == C_ER && canMod) begin
      start = 1'b1; pendLen = EC; mErasing = 1'b1;
    end
    xfer(d, start, r);
    if (op == C_WR && start) mMem[a] = d;
    if (op == C_ER && start) begin
      for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
      mLock = 0;
    end
    if (op == C_EN && a1 == C_KEY) mEn = 1'b1;
    if (op == C_LK && canMod && mLock != 3 && int'(d[1:0]) == mLock + 1) mLock = int'(d[1:0]);
    if (op == C_RD || op == C_SG) check(tag, r, exp);
  endtask

  task automatic pageOp(string tag, logic [7:0] op, logic [3:0] hi, int seed);
    logic [7:0] r, exp, d;
    int a;
    bit ok, start;
    xfer(op, 1'b0, r);
    xfer({4'h0, hi}, 1'b0, r);
    for (int k = 0; k < 256; k++) begin
      a = (int'(hi) * 256 + k) % DEPTH;
      if (op == C_PRD) begin
        exp = mRead(a);
        xfer(8'h00, 1'b0, r);
        check(tag, r, exp);
      end else begin
        d = 8'(k * 7 + seed);
        ok = mEn && mTmr == 0 && mPend == 0 && mLock == 0;
        start = ok && (k == 255);
        if (start) begin
          pendLen = WC; mErasing = 1'b0; mLastAddr = a;
        end
        xfer(d, start, r);
        if (ok) mMem[a] = d;
      end
    end
  endtask

  task automatic waitIdle();
    while (mTmr > 0 || mPend > 0) waitClk(1);
    waitClk(4);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
    waitClk(3);
    check("R2 reset miso", {7'b0, miso}, 8'h00);
    check("R3 reset busy", {7'b0, busy}, 8'h00);
    rstN = 1'b1;
    chkOn = 1'b1;
    progMode = 1'b1;
    waitClk(70);

    // R1: nothing acted on before enable
    frame("R1 write before enable", C_WR, 8'h00, 8'h05, 8'h3C);
    frame("R1 read before enable", C_RD, 8'h00, 8'h05, 8'h00);
    frame("R1 enable", C_EN, C_KEY, 8'h00, 8'h00);

    // R6: erase, zero reads while erasing
    frame("R6 erase", C_ER, 8'h00, 8'h00, 8'h00);
    frame("R6 read during erase", C_RD, 8'h00, 8'h05, 8'h00);
    waitIdle();
    frame("R6 read after erase", C_RD, 8'h00, 8'h05, 8'h00);

    // R3 R4 R5 R12: write, rejected write while busy, polling
    frame("R3 write", C_WR, 8'h01, 8'h23, 8'hA5);
    frame("R12 write while busy", C_WR, 8'h00, 8'h10, 8'h77);
    frame("R5 poll msb set", C_RD, 8'h01, 8'h23, 8'h00);
    waitIdle();
    frame("R4 read back", C_RD, 8'h01, 8'h23, 8'h00);
    frame("R12 busy write ignored", C_RD, 8'h00, 8'h10, 8'h00);
    frame("R3 write wrap", C_WR, 8'h04, 8'hC5, 8'h3E);
    waitIdle();
    frame("R3 wrapped read", C_RD, 8'h00, 8'hC5, 8'h00);
    frame("R3 write msb clear", C_WR, 8'h01, 8'hE7, 8'h5A);
    frame("R5 poll msb clear", C_RD, 8'h01, 8'hE7, 8'h00);
    waitIdle();
    frame("R2 R4 read after poll", C_RD, 8'h01, 8'hE7, 8'h00);

    // R12: unknown opcode, framing realigns
    frame("R12 unknown opcode", 8'h77, 8'h01, 8'h23, 8'h00);
    frame("R12 realigned read", C_RD, 8'h01, 8'h23, 8'h00);

    // R9: signature bytes
    frame("R9 sig 000", C_SG, 8'h00, 8'h00, 8'h00);
    frame("R9 sig 100", C_SG, 8'h01, 8'h00, 8'h00);
    frame("R9 sig 200", C_SG, 8'h02, 8'h00, 8'h00);
    frame("R9 sig 300", C_SG, 8'h03, 8'h00, 8'h00);

    // R7 R8: page write then page read
    pageOp("R7 page write", C_PWR, 4'h2, 3);
    frame("R7 poll last page byte", C_RD, 8'h02, 8'hFF, 8'h00);
    waitIdle();
    pageOp("R8 page read", C_PRD, 4'h2, 0);
    frame("R8 next frame decoded", C_RD, 8'h01, 8'h23, 8'h00);

    // R10 R11: lock ladder
    frame("R10 skipped level", C_LK, 8'h00, 8'h00, 8'h02);
    frame("R10 write still open", C_WR, 8'h00, 8'h30, 8'h11);
    waitIdle();
    frame("R10 read open", C_RD, 8'h00, 8'h30, 8'h00);
    frame("R10 level 1", C_LK, 8'h00, 8'h00, 8'h01);
    frame("R11 write at level 1", C_WR, 8'h00, 8'h31, 8'h22);
    frame("R11 read at level 1", C_RD, 8'h00, 8'h31, 8'h00);
    frame("R11 read ok level 1", C_RD, 8'h00, 8'h30, 8'h00);
    frame("R10 skip to 3", C_LK, 8'h00, 8'h00, 8'h03);
    frame("R10 level 2", C_LK, 8'h00, 8'h00, 8'h02);
    frame("R11 read at level 2", C_RD, 8'h00, 8'h30, 8'h00);
    frame("R9 sig at level 2", C_SG, 8'h01, 8'h00, 8'h00);
    frame("R10 level 3", C_LK, 8'h00, 8'h00, 8'h03);
    frame("R10 level 0 request", C_LK, 8'h00, 8'h00, 8'h00);
    frame("R9 sig at level 3", C_SG, 8'h01, 8'h00, 8'h00);
    frame("R6 erase clears lock", C_ER, 8'h00, 8'h00, 8'h00);
    waitIdle();
    frame("R6 read after unlock", C_RD, 8'h00, 8'h30, 8'h00);
    frame("R6 sig after unlock", C_SG, 8'h00, 8'h00, 8'h00);

    // R1: leaving programming mode drops the enable
    progMode = 1'b0;
    waitClk(10);
    mEn = 1'b0;
    progMode = 1'b1;
    waitClk(70);
    frame("R1 read after mode drop", C_RD, 8'h01, 8'h23, 8'h00);
    frame("R1 write after mode drop", C_WR, 8'h01, 8'h23, 8'h00);
    frame("R1 re-enable", C_EN, C_KEY, 8'h00, 8'h00);
    frame("R1 read after re-enable", C_RD, 8'h01, 8'h23, 8'h00);

    waitClk(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule